// File: doc/BRIEF.md
# Strobed Parallel Register Port

This block is the device end of an asynchronous parallel bus that a host drives. A single 8-bit lane carries both register indices and register data. The host selects the phase with an active-low address strobe and an active-low data strobe, and marks the direction with a write flag. The device acknowledges each phase on a wait line. A four-phase handshake gives the host the full set of 256 byte-wide registers, and any of them can be read or written at any time.

The pad inputs pass through two-flop synchronizers before a small sequencer looks at them. An address phase latches the lane byte as the current index. A write data phase produces a single write pulse toward the fabric, carrying the host byte. A read data phase issues a read request, captures the byte that the fabric returns, and drives it onto the lane with the output enable raised. The fabric must return read data in the cycle after the request pulse and hold it there. The latched index persists across any number of data phases.

Top module: `strobed_reg_port`

## Requirements
- R1: While the synchronous active-high reset `rst` is high and after it is released, `padWait`, `padOutEn`, `regWrPulse` and `regRdReq` are 0 and `regAddr` is 0x00. This holds even when reset arrives after an index has been latched.
- R2: An address phase (`padAddrStbN`=0, `padWrite`=1, `padDataStbN`=1) latches `padDataIn` as the index. By the time `padWait` goes high, `regAddr` equals that byte.
- R3: A write data phase (`padDataStbN`=0, `padWrite`=1) produces exactly one single-cycle `regWrPulse`, with `regWrData` equal to the host byte and `regAddr` equal to the latched index.
- R4: A read data phase (`padDataStbN`=0, `padWrite`=0) produces exactly one single-cycle `regRdReq` at the latched index. While `padWait` is high, `padDataOut` shows the `regRdData` byte that the fabric returned in the cycle after that request.
- R5: `padOutEn` is 1 only during a read data phase. It is 1 while `padWait` is high in that phase. It is 0 during address and write phases, and it is already 0 by the time `padWait` falls after the host releases the data strobe.
- R6: The handshake is four-phase. `padWait` rises only after a phase has been serviced. It stays high for as long as the host holds its strobe low, and it returns to 0 only after both strobes are seen high.
- R7: The latched index does not change during data phases. Repeated reads and writes reach the same register until the next address phase.
- R8: If both strobes are low at once, the block ignores both. `padWait` stays 0, no write pulse or read request occurs, and `regAddr` keeps its value.
- R9: An address strobe with `padWrite`=0 is ignored. `padWait` stays 0 and `regAddr` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| padDataIn | input | 8 | Lane value driven by the host (index or write data) |
| padDataOut | output | 8 | Read byte driven onto the lane when enabled |
| padOutEn | output | 1 | Lane driver enable, high only in a read data phase |
| padAddrStbN | input | 1 | Address strobe from the host, active low |
| padDataStbN | input | 1 | Data strobe from the host, active low |
| padWrite | input | 1 | Write flag from the host, 1 = write / address phase |
| padWait | output | 1 | Phase-serviced acknowledge to the host |
| regAddr | output | 8 | Currently latched register index |
| regWrData | output | 8 | Byte to be written into the fabric register |
| regWrPulse | output | 1 | Single-cycle write strobe toward the fabric |
| regRdReq | output | 1 | Single-cycle read request toward the fabric |
| regRdData | input | 8 | Fabric register value, valid the cycle after `regRdReq` |

## Verification
The assertions assume a host that follows the four-phase handshake. The host presents the lane byte and the write flag no later than the strobe edge. It keeps them steady until `padWait` rises, and it does not start a new phase until `padWait` has fallen. The bench's host tasks follow that order exactly, and they wait for each wait edge before moving on. Strobe overlap and an address strobe without the write flag appear only in directed tests. Each of those tests starts from an idle handshake and releases all strobes before normal traffic resumes.

// File: rtl/strobe_port_pkg.sv
package strobe_port_pkg;
  localparam int LANE_W = 8;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic latchAddr;
    logic captureWr;
    logic loadRd;
    logic idle;
  } portCtrl_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RESET_VAL;
      else if (s == 0) chain[s] <= din;
      else chain[s] <= chain[(s > 0) ? s - 1 : 0];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/strobe_port_ctrl.sv
module strobe_port_ctrl
  import strobe_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      addrStb,
  input  logic      dataStb,
  input  logic      wrFlag,
  output portCtrl_t ctrl,
  output logic      waitOut,
  output logic      rdReq
);
  typedef enum logic [1:0] {S_IDLE, S_RDREQ, S_RDLOAD, S_ACK} state_t;
  state_t state, nextState;

  always_comb begin
    nextState = state;
    ctrl = '0;
    ctrl.idle = (state == S_IDLE);
    case (state)
      S_IDLE: begin
        if (addrStb && dataStb) begin
          nextState = S_IDLE;           // overlap: ignored
        end else if (addrStb && wrFlag) begin
          ctrl.latchAddr = 1'b1;
          nextState = S_ACK;
        end else if (dataStb && wrFlag) begin
          ctrl.captureWr = 1'b1;
          nextState = S_ACK;
        end else if (dataStb) begin
          nextState = S_RDREQ;
        end
      end
      S_RDREQ:  nextState = S_RDLOAD;
      S_RDLOAD: begin
        ctrl.loadRd = 1'b1;
        nextState = S_ACK;
      end
      S_ACK:    if (!addrStb && !dataStb) nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else state <= nextState;
  end

  assign waitOut = (state == S_ACK);
  assign rdReq   = (state == S_RDREQ);
endmodule

// File: rtl/strobe_port_dpath.sv
module strobe_port_dpath
  import strobe_port_pkg::*;
#(
  parameter int W = LANE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  portCtrl_t    ctrl,
  input  logic [W-1:0] laneIn,
  input  logic         dataStb,
  input  logic [W-1:0] rdData,
  output logic [W-1:0] addrQ,
  output logic [W-1:0] wrDataQ,
  output logic         wrPulseQ,
  output logic [W-1:0] laneOut,
  output logic         outEn
);
  logic oeQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ    <= '0;
      wrDataQ  <= '0;
      wrPulseQ <= 1'b0;
      laneOut  <= '0;
      oeQ      <= 1'b0;
    end else begin
      wrPulseQ <= ctrl.captureWr;
      if (ctrl.latchAddr) addrQ <= laneIn;
      if (ctrl.captureWr) wrDataQ <= laneIn;
      if (ctrl.loadRd) begin
        laneOut <= rdData;
        oeQ     <= 1'b1;
      end else if (ctrl.idle) begin
        oeQ <= 1'b0;
      end
    end
  end

  // enable falls as soon as the synchronized data strobe goes inactive
  assign outEn = oeQ && dataStb;
endmodule

// File: rtl/strobed_reg_port.sv
module strobed_reg_port
  import strobe_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [LANE_W-1:0] padDataIn,
  output logic [LANE_W-1:0] padDataOut,
  output logic              padOutEn,
  input  logic              padAddrStbN,
  input  logic              padDataStbN,
  input  logic              padWrite,
  output logic              padWait,
  output logic [LANE_W-1:0] regAddr,
  output logic [LANE_W-1:0] regWrData,
  output logic              regWrPulse,
  output logic              regRdReq,
  input  logic [LANE_W-1:0] regRdData
);
  localparam int SW = LANE_W + 3;

  logic [SW-1:0] rawIn, syncOut;
  logic [LANE_W-1:0] laneSync;
  logic addrStbAct, dataStbAct, wrSync;
  portCtrl_t ctrlBus;

  assign rawIn = {padDataIn, padWrite, padDataStbN, padAddrStbN};

  strobe_sync #(
    .WIDTH(SW), .STAGES(SYNC_STAGES), .RESET_VAL({{(LANE_W+1){1'b0}}, 2'b11})
  ) u_sync (
    .clk(clk), .rst(rst), .din(rawIn), .dout(syncOut)
  );

  assign addrStbAct = ~syncOut[0];
  assign dataStbAct = ~syncOut[1];
  assign wrSync     = syncOut[2];
  assign laneSync   = syncOut[SW-1:3];

  strobe_port_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .addrStb(addrStbAct), .dataStb(dataStbAct), .wrFlag(wrSync),
    .ctrl(ctrlBus), .waitOut(padWait), .rdReq(regRdReq)
  );

  strobe_port_dpath #(.W(LANE_W)) u_dpath (
    .clk(clk), .rst(rst), .ctrl(ctrlBus),
    .laneIn(laneSync), .dataStb(dataStbAct), .rdData(regRdData),
    .addrQ(regAddr), .wrDataQ(regWrData), .wrPulseQ(regWrPulse),
    .laneOut(padDataOut), .outEn(padOutEn)
  );
endmodule

// File: rtl/strobed_reg_port_chk.sv
module strobed_reg_port_chk
  import strobe_port_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              aStb,
  input logic              dStb,
  input logic              wrS,
  input logic              padWait,
  input logic              padOutEn,
  input logic              regWrPulse,
  input logic              regRdReq,
  input logic [LANE_W-1:0] regAddr,
  input portCtrl_t         ctrlBus
);
  p_wr_single_r3: assert property (@(posedge clk) disable iff (rst)
    regWrPulse |=> !regWrPulse);

  p_rd_single_r4: assert property (@(posedge clk) disable iff (rst)
    regRdReq |=> !regRdReq);

  p_oe_read_only_r5: assert property (@(posedge clk) disable iff (rst)
    padOutEn |-> (dStb && !wrS && !aStb));

  p_wait_held_r6: assert property (@(posedge clk) disable iff (rst)
    (padWait && (aStb || dStb)) |=> padWait);

  p_addr_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(regAddr) |-> $past(ctrlBus.latchAddr));

  p_overlap_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrlBus.idle && aStb && dStb) |=> (!padWait && !regWrPulse && !regRdReq));

  p_addr_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
    (ctrlBus.idle && aStb && !dStb && !wrS) |=> !padWait);
endmodule

bind strobed_reg_port strobed_reg_port_chk u_chk (
  .clk(clk), .rst(rst),
  .aStb(addrStbAct), .dStb(dataStbAct), .wrS(wrSync),
  .padWait(padWait), .padOutEn(padOutEn),
  .regWrPulse(regWrPulse), .regRdReq(regRdReq),
  .regAddr(regAddr), .ctrlBus(ctrlBus)
);

// File: tb/strobed_reg_port_tb.sv
`timescale 1ns/1ps
module strobed_reg_port_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] padDataIn = 8'h00;
  logic [7:0] padDataOut;
  logic padOutEn, padWait;
  logic padAddrStbN = 1'b1;
  logic padDataStbN = 1'b1;
  logic padWrite = 1'b0;
  logic [7:0] regAddr, regWrData, regRdData;
  logic regWrPulse, regRdReq;

  int tests = 0;
  int fails = 0;
  int wrCount = 0;
  int rdCount = 0;
  logic [7:0] lastWrAddr, lastWrData;
  logic [7:0] mem [256];

  always #2 clk = ~clk;

  strobed_reg_port u_dut (
    .clk(clk), .rst(rst),
    .padDataIn(padDataIn), .padDataOut(padDataOut), .padOutEn(padOutEn),
    .padAddrStbN(padAddrStbN), .padDataStbN(padDataStbN), .padWrite(padWrite),
    .padWait(padWait),
    .regAddr(regAddr), .regWrData(regWrData), .regWrPulse(regWrPulse),
    .regRdReq(regRdReq), .regRdData(regRdData)
  );

  // fabric register bank model: read data valid the cycle after the request
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      regRdData <= 8'h00;
    end else begin
      if (regWrPulse) begin
        mem[regAddr] <= regWrData;
        lastWrAddr <= regAddr;
        lastWrData <= regWrData;
        wrCount <= wrCount + 1;
      end
      if (regRdReq) begin
        regRdData <= mem[regAddr];
        rdCount <= rdCount + 1;
      end
    end
  end

  task automatic check(input string req, input bit ok, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pollWait(input logic lvl, output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 64; n++) begin
      @(negedge clk);
      if (padWait === lvl) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic hostAddr(input logic [7:0] a);
    bit ok;
    @(negedge clk);
    padDataIn = a; padWrite = 1'b1; padAddrStbN = 1'b0;
    pollWait(1'b1, ok);
    check("R6 wait rises on address phase", ok, {7'd0, padWait}, 8'd1);
    check("R2 latched index", regAddr === a, regAddr, a);
    check("R5 no enable in address phase", padOutEn === 1'b0, {7'd0, padOutEn}, 8'd0);
    padAddrStbN = 1'b1;
    pollWait(1'b0, ok);
    check("R6 wait falls after release", ok, {7'd0, padWait}, 8'd0);
  endtask

  task automatic hostWrite(input logic [7:0] d);
    bit ok;
    int c0;
    logic [7:0] aNow;
    c0 = wrCount;
    aNow = regAddr;
    @(negedge clk);
    padDataIn = d; padWrite = 1'b1; padDataStbN = 1'b0;
    pollWait(1'b1, ok);
    check("R6 wait rises on write phase", ok, {7'd0, padWait}, 8'd1);
    check("R5 no enable in write phase", padOutEn === 1'b0, {7'd0, padOutEn}, 8'd0);
    padDataStbN = 1'b1;
    pollWait(1'b0, ok);
    check("R3 one write pulse", wrCount == c0 + 1, 8'(wrCount - c0), 8'd1);
    check("R3 write data", lastWrData === d, lastWrData, d);
    check("R7 write address", lastWrAddr === aNow, lastWrAddr, aNow);
  endtask

  task automatic hostRead(input logic [7:0] exp);
    bit ok;
    int c0;
    c0 = rdCount;
    @(negedge clk);
    padDataIn = 8'hEE; padWrite = 1'b0; padDataStbN = 1'b0;
    pollWait(1'b1, ok);
    check("R6 wait rises on read phase", ok, {7'd0, padWait}, 8'd1);
    check("R4 read data on lane", padDataOut === exp, padDataOut, exp);
    check("R5 enable during read", padOutEn === 1'b1, {7'd0, padOutEn}, 8'd1);
    padDataStbN = 1'b1;
    pollWait(1'b0, ok);
    check("R5 enable off when wait falls", padOutEn === 1'b0, {7'd0, padOutEn}, 8'd0);
    check("R4 one read request", rdCount == c0 + 1, 8'(rdCount - c0), 8'd1);
  endtask

  localparam logic [1:0] OP_A = 2'd0, OP_W = 2'd1, OP_R = 2'd2;
  typedef struct packed { logic [1:0] op; logic [7:0] val; } vec_t;
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{OP_A, 8'h05}, '{OP_W, 8'h3C}, '{OP_R, 8'h3C},
    '{OP_W, 8'hA5}, '{OP_R, 8'hA5}, '{OP_R, 8'hA5},
    '{OP_A, 8'hFF}, '{OP_W, 8'h81}, '{OP_R, 8'h81},
    '{OP_A, 8'h00}, '{OP_R, 8'h00},
    '{OP_A, 8'h05}, '{OP_R, 8'hA5},
    '{OP_A, 8'hFF}
  };

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ok;
    int c0, r0;
    logic [7:0] aKeep;
    repeat (4) @(negedge clk);
    // R1 state during reset
    check("R1 wait in reset", padWait === 1'b0, {7'd0, padWait}, 8'd0);
    check("R1 enable in reset", padOutEn === 1'b0, {7'd0, padOutEn}, 8'd0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 index after reset", regAddr === 8'h00, regAddr, 8'h00);
    check("R1 pulses after reset", (regWrPulse | regRdReq) === 1'b0, {6'd0, regWrPulse, regRdReq}, 8'd0);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_A: hostAddr(VECS[i].val);
        OP_W: hostWrite(VECS[i].val);
        default: hostRead(VECS[i].val);
      endcase
    end

    // R6: wait holds while the strobe stays low
    @(negedge clk);
    padDataIn = 8'h12; padWrite = 1'b1; padAddrStbN = 1'b0;
    pollWait(1'b1, ok);
    repeat (12) @(negedge clk);
    check("R6 wait held with strobe low", padWait === 1'b1, {7'd0, padWait}, 8'd1);
    padAddrStbN = 1'b1;
    pollWait(1'b0, ok);
    check("R6 wait released", ok, {7'd0, padWait}, 8'd0);

    // R8: overlapping strobes are ignored
    aKeep = regAddr;
    c0 = wrCount; r0 = rdCount; ok = 1'b1;
    @(negedge clk);
    padDataIn = 8'h77; padWrite = 1'b1; padAddrStbN = 1'b0; padDataStbN = 1'b0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (padWait !== 1'b0) ok = 1'b0;
    end
    check("R8 no wait on overlap", ok, {7'd0, ok}, 8'd1);
    padWrite = 1'b0;
    repeat (10) @(negedge clk);
    padAddrStbN = 1'b1; padDataStbN = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 index held", regAddr === aKeep, regAddr, aKeep);
    check("R8 no access", (wrCount == c0) && (rdCount == r0), 8'(wrCount - c0 + rdCount - r0), 8'd0);

    // R9: address strobe without write flag is ignored
    ok = 1'b1;
    @(negedge clk);
    padDataIn = 8'h33; padWrite = 1'b0; padAddrStbN = 1'b0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (padWait !== 1'b0) ok = 1'b0;
    end
    padAddrStbN = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 no wait", ok, {7'd0, ok}, 8'd1);
    check("R9 index held", regAddr === aKeep, regAddr, aKeep);

    // traffic still works after the illegal cases
    hostAddr(8'h05);
    hostRead(8'hA5);

    // R1: reset after an index was latched
    hostAddr(8'h9A);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 index cleared by reset", regAddr === 8'h00, regAddr, 8'h00);
    check("R1 wait low after reset", padWait === 1'b0, {7'd0, padWait}, 8'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule